// File: doc/BRIEF.md
# Event-Selectable Performance Monitor Unit

This block counts what a processor core does while it runs. It has one cycle counter and two general event counters. The cycle counter tracks elapsed clock cycles. Each general counter has an 8-bit selector that picks its source from a bus of single-cycle event pulses. Those pulses report procedure calls and returns, return-stack prediction outcomes, write-buffer drains and two external trigger lines. One code counts both trigger lines together and adds two in a cycle when both fire.

Software reaches the block through a plain register port. The port has a 2-bit address, a write strobe, write data and a read bus that returns data in the same cycle. The control word holds the following:
- the global enable;
- two write-one clear actions;
- a prescale mode, in which the cycle counter advances once every 2^PRE_W cycles, so the default build wraps only every 2^38 cycles;
- three interrupt enables;
- three sticky overflow flags;
- both event selectors.

The interrupt line is raised while any flag is set together with its enable. The port is a register interface, not a data stream, so it has no valid/ready handshake. A write takes effect at the clock edge on which `reg_wr` is high.

Top module: `perf_monitor_unit`

## Requirements
- R1: After reset, all three counters, the prescaler, every control field and every overflow flag are zero, and `irq` is low.
- R2: While control bit 0 (enable) is 0, no counter changes except by a direct register write or a clear action.
- R3: Writing 1 to control bit 1 clears both event counters on that edge. Control bits 1 and 2 always read as 0.
- R4: Writing 1 to control bit 2 clears the cycle counter and the prescaler on that edge.
- R5: With enable set and control bit 3 (prescale) at 0, the cycle counter advances by one on every cycle. With bit 3 at 1, it advances once every 2^PRE_W enabled cycles.
- R6: The selector codes map to `evt_pulse` bits as follows:
  - 0x20 counts bit 0 (trigger 0);
  - 0x21 counts bit 1 (trigger 1);
  - 0x23 counts bit 2 (procedure call);
  - 0x24 counts bit 3 (procedure return);
  - 0x25 counts bit 4 (return predicted);
  - 0x26 counts bit 5 (return mispredicted);
  - 0x12 counts bit 6 (write-buffer drain).
- R7: Code 0x22 adds the number of asserted trigger bits (`evt_pulse[1:0]`) in that cycle, which is 0, 1 or 2.
- R8: Code 0xFF adds one on every enabled cycle. Any code not listed in R6 or R7 never changes the counter.
- R9: A counter that wraps past its all-ones value sets its sticky overflow flag. The flags are control bits 8 (event counter 0), 9 (event counter 1) and 10 (cycle counter). Writing 1 to a flag bit clears it. If a flag is set and cleared on the same edge, it ends set.
- R10: `irq` is high exactly while some overflow flag is set and its enable is set. The enables are control bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R11: A register write to a counter on the same edge as an increment or a clear loads the written value.
- R12: The register map is as follows:
  - address 0 is the control word, with selector 0 at bits 23:16 and selector 1 at bits 31:24;
  - address 1 is the cycle counter;
  - address 2 is event counter 0;
  - address 3 is event counter 1.
  
  Counters read zero-extended, and reads take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 7 | Single-cycle event pulses, bit meanings as in R6 |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with CNT_W = 8 and PRE_W = 3. With an 8-bit counter, wraps, sticky flags and the interrupt occur within a few hundred cycles instead of billions. With a 3-bit prescaler, the divided cycle count can be seen within tens of cycles. Near-full preload values are written often, so a two-count step across the wrap point is reached frequently. These values also let the write-versus-increment collisions be reached.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // event selector codes
  localparam logic [7:0] EV_TRIG0    = 8'h20;
  localparam logic [7:0] EV_TRIG1    = 8'h21;
  localparam logic [7:0] EV_TRIG_ANY = 8'h22;
  localparam logic [7:0] EV_CALL     = 8'h23;
  localparam logic [7:0] EV_RET      = 8'h24;
  localparam logic [7:0] EV_RET_HIT  = 8'h25;
  localparam logic [7:0] EV_RET_MISS = 8'h26;
  localparam logic [7:0] EV_WB_DRAIN = 8'h12;
  localparam logic [7:0] EV_CYCLE    = 8'hFF;

  // positions on the event pulse bus
  localparam int EB_TRIG0 = 0;
  localparam int EB_TRIG1 = 1;
  localparam int EB_CALL  = 2;
  localparam int EB_RET   = 3;
  localparam int EB_HIT   = 4;
  localparam int EB_MISS  = 5;
  localparam int EB_DRAIN = 6;
  localparam int EVT_W    = 7;

  // control word fields
  localparam int CB_EN      = 0;
  localparam int CB_CLR_EV  = 1;
  localparam int CB_CLR_CYC = 2;
  localparam int CB_PRE     = 3;
  localparam int CB_IE_LO   = 4;
  localparam int CB_OVF_LO  = 8;
  localparam int CB_SEL0_LO = 16;
  localparam int CB_SEL1_LO = 24;

  // counter index: 0 = event 0, 1 = event 1, 2 = cycle
  localparam int NCNT = 3;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pmu_event_decode.sv
module pmu_event_decode
  import pmu_pkg::*;
(
  input  logic [7:0]       sel,
  input  logic [EVT_W-1:0] evt,
  output logic [1:0]       inc
);
  always_comb begin
    unique case (sel)
      EV_TRIG0:    inc = {1'b0, evt[EB_TRIG0]};
      EV_TRIG1:    inc = {1'b0, evt[EB_TRIG1]};
      EV_TRIG_ANY: inc = {1'b0, evt[EB_TRIG0]} + {1'b0, evt[EB_TRIG1]};
      EV_CALL:     inc = {1'b0, evt[EB_CALL]};
      EV_RET:      inc = {1'b0, evt[EB_RET]};
      EV_RET_HIT:  inc = {1'b0, evt[EB_HIT]};
      EV_RET_MISS: inc = {1'b0, evt[EB_MISS]};
      EV_WB_DRAIN: inc = {1'b0, evt[EB_DRAIN]};
      EV_CYCLE:    inc = 2'd1;
      default:     inc = 2'd0;
    endcase
  end

  always_comb begin
    if (inc == 2'd2) begin
      assert_double_step_R7: assert (sel == EV_TRIG_ANY && evt[1:0] == 2'b11);
    end
  end
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mode,
  input  logic clr,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = en && (!mode || (pre_q == '1));

  always_ff @(posedge clk) begin
    if (!rst_n)           pre_q <= '0;
    else if (clr || !mode) pre_q <= '0;
    else if (en)          pre_q <= pre_q + 1'b1;
  end

  assert_divided_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && tick) |=> !(mode && tick));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  assign sum  = {1'b0, cnt_q} + (W+1)'(inc);
  assign wrap = en && !wr && !clr && sum[W];
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (wr)  cnt_q <= wdata;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= sum[W-1:0];
  end

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wdata));
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> cnt_q == '0);
  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/perf_monitor_unit.sv
module perf_monitor_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [EVT_W-1:0] evt_pulse,
  output logic             irq
);
  logic            en_q, pre_q;
  logic [NCNT-1:0] ie_q, ovf_q, wrap_v, clr_mask;
  logic [7:0]      sel_q [2];
  logic [CNT_W-1:0] cnt_v [NCNT];
  logic            ctrl_wr, clr_ev, clr_cyc, cyc_tick;

  assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
  assign clr_ev   = ctrl_wr && reg_wdata[CB_CLR_EV];
  assign clr_cyc  = ctrl_wr && reg_wdata[CB_CLR_CYC];
  assign clr_mask = ctrl_wr ? reg_wdata[CB_OVF_LO +: NCNT] : '0;

  // event counters
  for (genvar i = 0; i < 2; i++) begin : g_ev
    logic [1:0] ev_inc;
    pmu_event_decode u_dec (
      .sel (sel_q[i]),
      .evt (evt_pulse),
      .inc (ev_inc)
    );
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .inc   (ev_inc),
      .wr    (reg_wr && (reg_addr == (i == 0 ? RA_EV0 : RA_EV1))),
      .wdata (reg_wdata[CNT_W-1:0]),
      .clr   (clr_ev),
      .cnt   (cnt_v[i]),
      .wrap  (wrap_v[i])
    );
  end

  // cycle counter behind the prescaler
  pmu_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .mode  (pre_q),
    .clr   (clr_cyc),
    .tick  (cyc_tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .inc   ({1'b0, cyc_tick}),
    .wr    (reg_wr && (reg_addr == RA_CYC)),
    .wdata (reg_wdata[CNT_W-1:0]),
    .clr   (clr_cyc),
    .cnt   (cnt_v[2]),
    .wrap  (wrap_v[2])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pre_q    <= 1'b0;
      ie_q     <= '0;
      ovf_q    <= '0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
    end else begin
      ovf_q <= (ovf_q & ~clr_mask) | wrap_v;
      if (ctrl_wr) begin
        en_q     <= reg_wdata[CB_EN];
        pre_q    <= reg_wdata[CB_PRE];
        ie_q     <= reg_wdata[CB_IE_LO +: NCNT];
        sel_q[0] <= reg_wdata[CB_SEL0_LO +: 8];
        sel_q[1] <= reg_wdata[CB_SEL1_LO +: 8];
      end
    end
  end

  assign irq = |(ovf_q & ie_q);

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = {sel_q[1], sel_q[0], 5'b0, ovf_q, 1'b0, ie_q,
                            pre_q, 2'b00, en_q};
      RA_CYC:  reg_rdata = 32'(cnt_v[2]);
      RA_EV0:  reg_rdata = 32'(cnt_v[0]);
      default: reg_rdata = 32'(cnt_v[1]);
    endcase
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ovf_q & ~clr_mask) & ~ovf_q) == '0));
  assert_wrap_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(wrap_v) & ~ovf_q) == '0));
endmodule

// File: tb/perf_monitor_unit_test.sv
`timescale 1ns/1ps
module perf_monitor_unit_test;
  localparam int CW = 8;
  localparam int PW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  perf_monitor_unit #(.CNT_W(CW), .PRE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq(irq)
  );

  // reference model
  logic          m_en, m_pre;
  logic [2:0]    m_ie, m_ovf;
  logic [7:0]    m_sel [2];
  logic [CW-1:0] m_cnt [3];
  logic [PW-1:0] m_pc;

  task automatic model_reset();
    m_en = 0; m_pre = 0; m_ie = 0; m_ovf = 0; m_pc = 0;
    m_sel[0] = 0; m_sel[1] = 0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
  endtask

  function automatic int ev_inc(input logic [7:0] s, input logic [6:0] e);
    case (s)
      8'h20: return int'(e[0]);
      8'h21: return int'(e[1]);
      8'h22: return int'(e[0]) + int'(e[1]);
      8'h23: return int'(e[2]);
      8'h24: return int'(e[3]);
      8'h25: return int'(e[4]);
      8'h26: return int'(e[5]);
      8'h12: return int'(e[6]);
      8'hFF: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_sel[1], m_sel[0], 5'b0, m_ovf, 1'b0, m_ie, m_pre, 2'b00, m_en};
      2'd1: return 32'(m_cnt[2]);
      2'd2: return 32'(m_cnt[0]);
      default: return 32'(m_cnt[1]);
    endcase
  endfunction

  task automatic model_step(input logic [1:0] a, input logic w,
                            input logic [31:0] d, input logic [6:0] e);
    logic cw, clr_ev, clr_cy, tick;
    logic [2:0] wrapv;
    cw = w && (a == 2'd0);
    clr_ev = cw && d[1];
    clr_cy = cw && d[2];
    tick = m_en && (!m_pre || m_pc == '1);
    wrapv = 0;
    for (int i = 0; i < 3; i++) begin
      int inc, sum;
      logic wr_i, clr_i;
      inc   = (i < 2) ? (m_en ? ev_inc(m_sel[i], e) : 0) : (tick ? 1 : 0);
      wr_i  = w && (a == ((i == 0) ? 2'd2 : (i == 1) ? 2'd3 : 2'd1));
      clr_i = (i < 2) ? clr_ev : clr_cy;
      if (wr_i) m_cnt[i] = d[CW-1:0];
      else if (clr_i) m_cnt[i] = 0;
      else begin
        sum = int'(m_cnt[i]) + inc;
        wrapv[i] = (sum >= (1 << CW));
        m_cnt[i] = sum[CW-1:0];
      end
    end
    m_ovf = (m_ovf & ~(cw ? d[10:8] : 3'b0)) | wrapv;
    if (clr_cy || !m_pre) m_pc = 0;
    else if (m_en) m_pc = m_pc + 1'b1;
    if (cw) begin
      m_en = d[0]; m_pre = d[3]; m_ie = d[6:4];
      m_sel[0] = d[23:16]; m_sel[1] = d[31:24];
    end
  endtask

  task automatic check(input string lbl, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", lbl, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] a, input logic w, input logic [31:0] d,
                       input logic [6:0] e, input string lbl);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d; evt_pulse = e;
    #1;
    check(lbl, reg_rdata, model_read(a));
    check("R10 irq", {31'b0, irq}, {31'b0, |(m_ovf & m_ie)});
    model_step(a, w, d, e);
  endtask

  task automatic peek(input logic [1:0] a, input string lbl);
    apply(a, 1'b0, 32'h0, 7'h0, lbl);
  endtask

  function automatic logic [31:0] ctrl(input logic en, input logic pre,
      input logic [2:0] ie, input logic [7:0] s0, input logic [7:0] s1,
      input logic [2:0] act, input logic [2:0] ovf_clr);
    return {s1, s0, 5'b0, ovf_clr, 1'b0, ie, pre, act[2:1], en};
  endfunction

  function automatic logic [7:0] pick_sel();
    logic [7:0] codes [10] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24,
                               8'h25, 8'h26, 8'h12, 8'hFF, 8'h55};
    if ($urandom % 8 == 0) return 8'($urandom);
    return codes[$urandom % 10];
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] codes [8] = '{8'h20, 8'h21, 8'h23, 8'h24, 8'h25, 8'h26, 8'h12, 8'h55};
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) peek(2'(a), "R1 reset value");

    // R2 disabled: selectors programmed but enable low
    apply(2'd0, 1'b1, ctrl(0, 0, 0, 8'hFF, 8'h22, 0, 0), 7'h0, "R2 setup");
    for (int k = 0; k < 4; k++) apply(2'(k), 1'b0, 0, 7'h7F, "R2 disabled hold");

    // R7 / R8 enable with 0xFF and 0x22
    apply(2'd0, 1'b1, ctrl(1, 0, 0, 8'hFF, 8'h22, 0, 0), 7'h0, "R8 setup");
    apply(2'd3, 1'b0, 0, 7'h03, "R7 both triggers");
    apply(2'd3, 1'b0, 0, 7'h01, "R7 one trigger");
    apply(2'd3, 1'b0, 0, 7'h03, "R7 both triggers");
    peek(2'd3, "R7 combined count");
    peek(2'd2, "R8 every cycle");

    // R11 write beats increment
    apply(2'd2, 1'b1, 32'h10, 7'h0, "R11 write");
    peek(2'd2, "R11 written value kept");

    // R3 clear event counters, action bits read 0
    apply(2'd0, 1'b1, ctrl(1, 0, 0, 8'hFF, 8'h22, 3'b010, 0), 7'h03, "R3 clear");
    peek(2'd0, "R3 action bits read zero");
    peek(2'd3, "R3 counter cleared");

    // R9 / R10 overflow, interrupt, flag clear
    apply(2'd0, 1'b1, ctrl(1, 0, 3'b001, 8'hFF, 8'h22, 0, 0), 7'h0, "R10 setup");
    apply(2'd2, 1'b1, 32'hFE, 7'h0, "R9 preload");
    for (int k = 0; k < 3; k++) peek(2'd0, "R9 flag after wrap");
    apply(2'd0, 1'b1, ctrl(1, 0, 3'b001, 8'hFF, 8'h22, 0, 3'b001), 7'h0, "R9 clear");
    peek(2'd0, "R9 flag cleared");
    apply(2'd3, 1'b1, 32'hFF, 7'h0, "R9 preload two-step");
    apply(2'd3, 1'b0, 0, 7'h03, "R7 wrap by two");
    peek(2'd0, "R9 flag by double step");

    // R6 each coded event, R8 unknown code
    foreach (codes[j]) begin
      apply(2'd0, 1'b1, ctrl(1, 0, 0, codes[j], 8'h00, 3'b010, 3'b111), 7'h0, "R6 setup");
      for (int k = 0; k < 6; k++) apply(2'd2, 1'b0, 0, 7'($urandom), "R6 event count");
      peek(2'd2, codes[j] == 8'h55 ? "R8 unknown code" : "R6 coded event");
    end

    // R4 / R5 prescale mode
    apply(2'd0, 1'b1, ctrl(1, 1, 0, 0, 0, 3'b100, 0), 7'h0, "R4 clear cycle");
    peek(2'd1, "R4 cycle cleared");
    for (int k = 0; k < 20; k++) peek(2'd1, "R5 divided count");
    apply(2'd0, 1'b1, ctrl(1, 0, 0, 0, 0, 0, 0), 7'h0, "R5 plain mode");
    for (int k = 0; k < 4; k++) peek(2'd1, "R5 plain count");

    // R12 random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]  a;
      logic        w;
      logic [31:0] d;
      a = 2'($urandom);
      w = ($urandom % 6 == 0);
      if (a == 2'd0)
        d = ctrl(($urandom % 8) != 0, ($urandom % 4) == 0, 3'($urandom),
                 pick_sel(), pick_sel(), 3'($urandom % 8 == 0 ? $urandom : 0),
                 3'($urandom));
      else
        d = ($urandom % 2) ? 32'hFC + ($urandom % 4) : $urandom;
      apply(a, w, d, 7'($urandom), "R12 random readback");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule